// File: doc/BRIEF.md
# PWM Timer Tick Tree

This block produces the count-enable ticks for five PWM timer channels, all in the domain of one peripheral clock. Two programmable prescalers divide the clock by a value from 1 to 256. Channels 0 and 1 share the first prescaler, and channels 2, 3 and 4 share the second. Each channel then divides its prescaler's tick by a power of two. A per-channel selector takes either that divided tick or the rising edges of an external timer clock input. External input 0 serves channels 0 and 1, and external input 1 serves channels 2 to 4. Every output is a one-cycle enable pulse, not a derived clock.

Software configures the block with two plain register writes. A prescaler write loads both 8-bit ratio fields. A selector write loads one 4-bit code per channel. Each code carries both the divide ratio and the source choice, so one write changes the two together. A build-time parameter chooses between two code encodings. Any write restarts the counters it affects. A new setting therefore never produces an early tick. The control pins are plain levels with no handshake, because nothing streams through the block.

Top module: `pwm_tick_tree`

## Requirements
- R1: Reset clears every prescaler and selector field to zero and holds `tick_o` low. After reset is released, variant A (`VARIANT_B`=0) ticks every channel on every 2nd cycle, and variant B ticks every channel on every cycle.
- R2: The prescaler word keeps bits [7:0] for channels 0–1 and bits [15:8] for channels 2–4. A field value n divides the peripheral clock by n+1.
- R3: The selector code of channel i sits in bits [4i+3:4i]. In variant A, codes 0–3 divide the prescaler tick by 2, 4, 8 or 16, code 4 selects the external input, and codes 5–15 divide by 16.
- R4: In variant B, codes 0–4 divide the prescaler tick by 1, 2, 4, 8 or 16, and codes 5–15 select the external input.
- R5: For a prescaler ratio P and a channel ratio R, a prescaler write at clock edge W gives the first tick in the cycle after edge W+R·P. Ticks then repeat every R·P cycles, each one cycle wide. This holds up to 256·16.
- R6: Any configuration write forces every `tick_o` low in the cycle after the write edge. A selector write restarts the channel dividers. A prescaler write also restarts both prescalers.
- R7: External input 0 drives only channels 0–1, and external input 1 drives only channels 2–4.
- R8: Each rising edge on a selected external input gives exactly one tick, in the cycle after the 3rd clock edge that follows the input change. A held level or a falling edge gives none.
- R9: A channel that selects its external input gives no tick from the prescaler or divider path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_we | input | 1 | Prescaler register write strobe |
| cfg_pre_wdata | input | 16 | Both prescaler ratio fields |
| cfg_sel_we | input | 1 | Selector register write strobe |
| cfg_sel_wdata | input | 20 | Five 4-bit channel selector codes |
| ext_clk_in | input | 2 | Asynchronous external timer clocks, one per channel group |
| tick_o | output | 5 | One-cycle count-enable per channel |

## Verification
Every divided result is due a fixed number of edges after the write that started it. That number is R·P edges for the first tick, and a further R·P for each later one. Each external result is due exactly three edges after the input changes. The bench counts clock edges from the write edge, or from the change of the external input. It samples on the falling edge of each cycle and compares the complete tick pattern of every channel at every step of that window. The cycle right after each write is checked for silence. A second instance built as variant B receives the same stimulus, so the two code encodings are checked against each other's timing rules.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int CODE_W = 4;
  localparam int DIVC_W = 4;

  typedef struct packed {
    logic       ext;
    logic [2:0] shift;
  } sel_dec_t;

  function automatic sel_dec_t decode_sel(input logic [CODE_W-1:0] code,
                                          input logic variant_b);
    sel_dec_t d;
    if (!variant_b) begin
      d.ext = (code == 4'd4);
      if (code < 4'd4) d.shift = 3'(code[1:0]) + 3'd1;
      else             d.shift = 3'd4;
    end else begin
      d.ext = (code >= 4'd5);
      if (code <= 4'd4) d.shift = code[2:0];
      else              d.shift = 3'd4;
    end
    return d;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] div_val,
  output logic         tick_o
);
  logic [W-1:0] cnt;

  assign tick_o = (cnt == div_val);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick_o) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_ext_sync.sv
module pwm_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [2:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[1:0], async_in};
  end

  assign rise_o = chain[1] & ~chain[2];
endmodule

// File: rtl/pwm_chan_div.sv
module pwm_chan_div
  import pwm_tick_pkg::*;
#(
  parameter bit VARIANT_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  input  logic              pre_tick,
  input  logic              ext_rise,
  output logic              div_tick_o,
  output logic              ext_sel_o,
  output logic              tick_o
);
  sel_dec_t          dec;
  logic [DIVC_W-1:0] mask;
  logic [DIVC_W-1:0] dcnt;

  assign dec        = decode_sel(code, VARIANT_B);
  assign mask       = DIVC_W'((5'd1 << dec.shift) - 5'd1);
  assign div_tick_o = pre_tick && (dcnt == mask);
  assign ext_sel_o  = dec.ext;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      dcnt <= '0;
    end else if (pre_tick) begin
      if (dcnt == mask) dcnt <= '0;
      else              dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) tick_o <= 1'b0;
    else if (dec.ext)      tick_o <= ext_rise;
    else                   tick_o <= div_tick_o;
  end
endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int GRP0_CH   = 2,
  parameter int PRE_W     = 8,
  parameter bit VARIANT_B = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_pre_we,
  input  logic [2*PRE_W-1:0]       cfg_pre_wdata,
  input  logic                     cfg_sel_we,
  input  logic [NUM_CH*CODE_W-1:0] cfg_sel_wdata,
  input  logic [1:0]               ext_clk_in,
  output logic [NUM_CH-1:0]        tick_o
);
  localparam int NUM_GRP = 2;

  logic [2*PRE_W-1:0]       pre_q;
  logic [NUM_CH*CODE_W-1:0] sel_q;
  logic [NUM_GRP-1:0]       ptick;
  logic [NUM_GRP-1:0]       ext_rise;
  logic [NUM_CH-1:0]        chan_dtick;
  logic [NUM_CH-1:0]        chan_ext;
  logic                     chan_restart;

  assign chan_restart = cfg_pre_we | cfg_sel_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      sel_q <= '0;
    end else begin
      if (cfg_pre_we) pre_q <= cfg_pre_wdata;
      if (cfg_sel_we) sel_q <= cfg_sel_wdata;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pwm_prescaler #(.W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_pre_we),
      .div_val (pre_q[g*PRE_W +: PRE_W]),
      .tick_o  (ptick[g])
    );
    pwm_ext_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk_in[g]),
      .rise_o   (ext_rise[g])
    );
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GRP = (i < GRP0_CH) ? 0 : 1;
    pwm_chan_div #(.VARIANT_B(VARIANT_B)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (chan_restart),
      .code       (sel_q[i*CODE_W +: CODE_W]),
      .pre_tick   (ptick[GRP]),
      .ext_rise   (ext_rise[GRP]),
      .div_tick_o (chan_dtick[i]),
      .ext_sel_o  (chan_ext[i]),
      .tick_o     (tick_o[i])
    );
  end
endmodule

// File: rtl/pwm_tick_tree_chk.sv
module pwm_tick_tree_chk #(
  parameter int NUM_CH  = 5,
  parameter int GRP0_CH = 2,
  parameter int PRE_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_pre_we,
  input logic               cfg_sel_we,
  input logic [NUM_CH-1:0]  tick_o,
  input logic [1:0]         ptick,
  input logic [1:0]         ext_rise,
  input logic [NUM_CH-1:0]  chan_dtick,
  input logic [NUM_CH-1:0]  chan_ext,
  input logic [2*PRE_W-1:0] pre_q
);
  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pre_we || cfg_sel_we) |=> (tick_o == '0));

  // R2
  pre_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q[PRE_W-1:0] == '0) |-> ptick[0]);

  for (genvar g = 0; g < 2; g++) begin : g_grp
    // R8
    ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[g] |=> !ext_rise[g]);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GRP = (i < GRP0_CH) ? 0 : 1;
    // R5
    div_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_dtick[i] |-> ptick[GRP]);
    // R9
    ext_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[i] && chan_ext[i]) |-> $past(ext_rise[GRP]));
  end
endmodule

bind pwm_tick_tree pwm_tick_tree_chk #(
  .NUM_CH (NUM_CH),
  .GRP0_CH(GRP0_CH),
  .PRE_W  (PRE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_pre_we (cfg_pre_we),
  .cfg_sel_we (cfg_sel_we),
  .tick_o     (tick_o),
  .ptick      (ptick),
  .ext_rise   (ext_rise),
  .chan_dtick (chan_dtick),
  .chan_ext   (chan_ext),
  .pre_q      (pre_q)
);

// File: tb/tb_pwm_tick_tree.sv
module tb_pwm_tick_tree;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_we, sel_we;
  logic [15:0] pre_wd;
  logic [19:0] sel_a, sel_b;
  logic [1:0]  ext_in;
  logic [4:0]  tick_a, tick_b;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm_tick_tree #(.VARIANT_B(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pre_we(pre_we), .cfg_pre_wdata(pre_wd),
    .cfg_sel_we(sel_we), .cfg_sel_wdata(sel_a), .ext_clk_in(ext_in), .tick_o(tick_a));

  pwm_tick_tree #(.VARIANT_B(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_pre_we(pre_we), .cfg_pre_wdata(pre_wd),
    .cfg_sel_we(sel_we), .cfg_sel_wdata(sel_b), .ext_clk_in(ext_in), .tick_o(tick_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Channel ratio from its code; 0 means the external input is selected.
  function automatic int exp_ratio(input logic [3:0] code, input bit var_b);
    if (!var_b) begin
      if (code == 4'd4) return 0;
      if (code < 4'd4)  return 2 << code;
      return 16;
    end
    if (code >= 4'd5) return 0;
    return 1 << code;
  endfunction

  task automatic do_write(input bit pw, input bit sw, input logic [15:0] pre,
                          input logic [19:0] sa, input logic [19:0] sb);
    @(negedge clk);
    pre_we = pw; sel_we = sw; pre_wd = pre; sel_a = sa; sel_b = sb;
    @(posedge clk);
    @(negedge clk);
    pre_we = 1'b0; sel_we = 1'b0;
    chk(tick_a == 5'd0, "R6", "variant A quiet after write", int'(tick_a), 0);
    chk(tick_b == 5'd0, "R6", "variant B quiet after write", int'(tick_b), 0);
  endtask

  // Starts at the falling edge right after the restart edge (window 0).
  task automatic measure(input string req, input logic [15:0] pre,
                         input logic [19:0] sa, input logic [19:0] sb);
    int rp [2][5];
    int bad [2][5];
    int first_e [2][5];
    int nwin = 8;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 5; i++) begin
        int p = (i < 2) ? int'(pre[7:0]) + 1 : int'(pre[15:8]) + 1;
        int r = exp_ratio((d == 0) ? sa[i*4 +: 4] : sb[i*4 +: 4], d == 1);
        rp[d][i] = r * p;
        bad[d][i] = 0;
        first_e[d][i] = -1;
        if (2 * rp[d][i] + 1 > nwin) nwin = 2 * rp[d][i] + 1;
      end
    end
    for (int e = 1; e <= nwin; e++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < 5; i++) begin
          logic got = (d == 0) ? tick_a[i] : tick_b[i];
          logic expv = (rp[d][i] != 0) && (e % rp[d][i] == 0);
          if (got !== expv) begin
            bad[d][i]++;
            if (first_e[d][i] < 0) first_e[d][i] = e * 2 + int'(got);
          end
        end
      end
    end
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 5; i++) begin
        string what = $sformatf("variant %s ch%0d ratio %0d mismatch at window %0d (got tick %0d)",
                                (d == 0) ? "A" : "B", i, rp[d][i],
                                first_e[d][i] / 2, first_e[d][i] % 2);
        chk(bad[d][i] == 0, req, what, bad[d][i], 0);
      end
    end
  endtask

  task automatic ext_step(input int which, input logic lvl, input logic [4:0] mask,
                          input string req);
    int bad_a = 0;
    int bad_b = 0;
    ext_in[which] = lvl;
    for (int e = 1; e <= 6; e++) begin
      logic [4:0] expv;
      @(negedge clk);
      expv = (e == 3) ? mask : 5'd0;
      if (tick_a !== expv) bad_a++;
      if (tick_b !== expv) bad_b++;
    end
    chk(bad_a == 0, req, $sformatf("variant A ext%0d level %0d tick windows wrong", which, lvl),
        bad_a, 0);
    chk(bad_b == 0, req, $sformatf("variant B ext%0d level %0d tick windows wrong", which, lvl),
        bad_b, 0);
  endtask

  task automatic t_reset();
    int seen = 0;
    rst_n = 1'b0; pre_we = 1'b0; sel_we = 1'b0; pre_wd = '0;
    sel_a = '0; sel_b = '0; ext_in = '0;
    repeat (4) begin
      @(negedge clk);
      if (tick_a != 5'd0 || tick_b != 5'd0) seen++;
    end
    chk(seen == 0, "R1", "ticks during reset", seen, 0);
    rst_n = 1'b1;
    chk(tick_a == 5'd0 && tick_b == 5'd0, "R1", "ticks at release",
        int'(tick_a | tick_b), 0);
    measure("R1", 16'h0000, 20'h0, 20'h0);
  endtask

  task automatic t_prescale_fields();
    do_write(1'b1, 1'b1, {8'd0, 8'd3}, 20'h0, 20'h0);
    measure("R2", {8'd0, 8'd3}, 20'h0, 20'h0);
    do_write(1'b1, 1'b1, {8'd4, 8'd0}, 20'h0, 20'h0);
    measure("R2", {8'd4, 8'd0}, 20'h0, 20'h0);
  endtask

  task automatic t_codes();
    logic [19:0] sa = {4'hF, 4'd3, 4'd2, 4'd1, 4'd0};
    logic [19:0] sb = {4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    do_write(1'b1, 1'b1, {8'd2, 8'd1}, sa, sb);
    measure("R3/R4", {8'd2, 8'd1}, sa, sb);
  endtask

  task automatic t_max_ratio();
    logic [19:0] sa = {5{4'd3}};
    logic [19:0] sb = {5{4'd4}};
    do_write(1'b1, 1'b1, {8'd7, 8'd255}, sa, sb);
    measure("R5", {8'd7, 8'd255}, sa, sb);
  endtask

  task automatic t_sel_only();
    logic [19:0] sa = {4'd3, 4'd3, 4'd2, 4'd1, 4'd0};
    logic [19:0] sb = {4'd0, 4'd1, 4'd2, 4'd3, 4'd4};
    do_write(1'b1, 1'b1, 16'h0000, 20'h0, 20'h0);
    repeat (5) @(negedge clk);
    do_write(1'b0, 1'b1, 16'hFFFF, sa, sb);
    measure("R6", 16'h0000, sa, sb);
  endtask

  task automatic t_mixed();
    logic [19:0] sa = {4'd2, 4'd1, 4'd4, 4'd0, 4'd3};
    logic [19:0] sb = {4'd3, 4'd0, 4'd5, 4'd2, 4'd1};
    do_write(1'b1, 1'b1, {8'd2, 8'd5}, sa, sb);
    measure("R9", {8'd2, 8'd5}, sa, sb);
  endtask

  task automatic t_external();
    logic [19:0] sa = {5{4'd4}};
    logic [19:0] sb = {5{4'd9}};
    do_write(1'b1, 1'b1, 16'h0000, sa, sb);
    measure("R9", 16'h0000, sa, sb);
    ext_step(0, 1'b1, 5'b00011, "R7");
    ext_step(0, 1'b1, 5'b00000, "R8");
    ext_step(0, 1'b0, 5'b00000, "R8");
    ext_step(1, 1'b1, 5'b11100, "R7");
    ext_step(1, 1'b0, 5'b00000, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale_fields();
    t_codes();
    t_max_ratio();
    t_sel_only();
    t_mixed();
    t_external();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule